// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the seven interrupt flags of a parallel-port and timer peripheral, together with a matching seven-bit enable mask, and raises a level interrupt request whenever an enabled flag is pending. Each interrupt source delivers a one-cycle set pulse: timer 1, timer 2, the shift register, and the two control lines of each port. Flags are cleared by the CPU in two ways. It can write ones to the flag register. It can also read or write a port data register, which clears the flags of that port's control lines.

The CPU reaches both registers over an 8-bit data bus with a 4-bit register select, an access strobe and a write qualifier. The enable register uses bit 7 of the written byte to pick a direction: it either sets or clears the enable bits that are written as one. Reading the flag register puts a summary bit in bit 7. The peripheral control register lives outside this block; its value is fed in so that the secondary control-line flags can be spared when that line runs as an independent interrupt input.

Top module: `ifc_irq_ctrl`

## Requirements
- R1: After reset, all flags and all enables are zero, `irq` is low, a flag-register read (select 0xD) returns 0x00 and an enable-register read (select 0xE) returns 0x80.
- R2: An enable write (`cs`=1, `we`=1, select 0xE) with `wdata[7]`=1 sets every enable bit whose data bit is 1 and leaves every other enable bit unchanged.
- R3: An enable write with `wdata[7]`=0 clears every enable bit whose data bit is 1 and leaves every other enable bit unchanged.
- R4: A read of select 0xE returns the enable bits in [6:0] and always returns 1 in bit 7.
- R5: A one-cycle pulse on `src_set[i]` sets flag i on the next clock edge, and the flag stays set until a clear. Flag bits are: 0 CA2, 1 CA1, 2 shift register, 3 CB2, 4 CB1, 5 timer 2, 6 timer 1.
- R6: A write to select 0xD clears each flag whose data bit in [6:0] is 1. Bit 7 of the written byte changes nothing.
- R7: A read of select 0xD returns the flags in [6:0], and bit 7 is 1 exactly when some flag and its enable are both set.
- R8: `irq` is high exactly when some flag and its enable are both set. It follows the register state in the same cycle.
- R9: Any access (read or write) to select 0x0 clears CB1 (bit 4). It also clears CB2 (bit 3), unless `ctl_mode & 0xA0` equals 0x20.
- R10: Any access to select 0x1 or 0xF clears CA1 (bit 1). It also clears CA2 (bit 0), unless `ctl_mode & 0x0A` equals 0x02.
- R11: When a set pulse and a clear for the same flag fall on the same clock edge, the flag ends up set.
- R12: A read of any select other than 0xD and 0xE returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read (when `cs` is high) |
| sel | input | 4 | Register select |
| wdata | input | 8 | Write data |
| ctl_mode | input | 8 | Current peripheral control register value |
| src_set | input | 7 | Per-source flag set pulses |
| rdata | output | 8 | Read data (combinational from current state) |
| irq | output | 1 | Level interrupt request |

## Verification
The enable register is written with bit 7 both high and low, and the patterns hold ones and zeros in mixed positions, so a set-only or clear-all implementation gives a wrong read-back. Flags are raised both on enabled and on disabled sources. This shows that the summary bit and `irq` follow the AND with the enables, and not just any pending flag. Port accesses are run with the control field in the independent mode, in a lookalike value that shares only one masked bit, and at zero. This separates a correct field compare from a single-bit test. Set pulses that land on the same edge as a flag write, or as a port access, show that the set has priority.

// File: rtl/ifc_pkg.sv
// Package: shared widths, register selects and flag bit positions for the
// interrupt flag/enable controller. Assumes a seven-source peripheral.
package ifc_pkg;
    localparam int unsigned NSRC = 7;
    localparam int unsigned DW   = 8;
    localparam int unsigned SW   = 4;

    // Register selects decoded by this block
    localparam logic [SW-1:0] SEL_PORTB  = 4'h0;
    localparam logic [SW-1:0] SEL_PORTA  = 4'h1;
    localparam logic [SW-1:0] SEL_PORTAQ = 4'hF;
    localparam logic [SW-1:0] SEL_FLAG   = 4'hD;
    localparam logic [SW-1:0] SEL_ENA    = 4'hE;

    // Flag bit positions
    localparam int unsigned FB_CA2 = 0;
    localparam int unsigned FB_CA1 = 1;
    localparam int unsigned FB_SHR = 2;
    localparam int unsigned FB_CB2 = 3;
    localparam int unsigned FB_CB1 = 4;
    localparam int unsigned FB_TM2 = 5;
    localparam int unsigned FB_TM1 = 6;

    // Control-line independent mode decode (field mask and match value)
    localparam logic [DW-1:0] CB2_FIELD_MASK  = 8'hA0;
    localparam logic [DW-1:0] CB2_INDEP_VALUE = 8'h20;
    localparam logic [DW-1:0] CA2_FIELD_MASK  = 8'h0A;
    localparam logic [DW-1:0] CA2_INDEP_VALUE = 8'h02;

    // Decoded per-cycle action for the register banks
    typedef struct packed {
        logic [NSRC-1:0] flag_clr;  // flags to clear this edge
        logic            ena_wr;    // enable register write strobe
        logic            ena_dir;   // 1 = set written ones, 0 = clear them
        logic [NSRC-1:0] ena_mask;  // enable bits addressed by the write
    } ifc_action_t;
endpackage

// File: rtl/ifc_access_decode.sv
// Module: ifc_access_decode
// Turns one bus access into the clear mask for the flags and the write
// action for the enable register. Purely combinational.
// Assumes: cs is high for exactly one cycle per access; ctl_mode is stable
// during the access.
module ifc_access_decode
    import ifc_pkg::*;
(
    input  logic          cs,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ctl_mode,
    output ifc_action_t   act
);
    logic hit_portb;
    logic hit_porta;
    logic hit_flag_wr;
    logic cb2_indep;
    logic ca2_indep;

    // Decode which register the current access addresses
    always_comb begin
        hit_portb   = cs && (sel == SEL_PORTB);
        hit_porta   = cs && ((sel == SEL_PORTA) || (sel == SEL_PORTAQ));
        hit_flag_wr = cs && we && (sel == SEL_FLAG);
        cb2_indep   = ((ctl_mode & CB2_FIELD_MASK) == CB2_INDEP_VALUE);
        ca2_indep   = ((ctl_mode & CA2_FIELD_MASK) == CA2_INDEP_VALUE);
    end

    // Build the clear mask from port side effects and explicit flag writes
    always_comb begin
        act.flag_clr = '0;
        if (hit_flag_wr) begin
            act.flag_clr = wdata[NSRC-1:0];
        end
        if (hit_portb) begin
            act.flag_clr[FB_CB1] = 1'b1;
            if (!cb2_indep) begin
                act.flag_clr[FB_CB2] = 1'b1;
            end
        end
        if (hit_porta) begin
            act.flag_clr[FB_CA1] = 1'b1;
            if (!ca2_indep) begin
                act.flag_clr[FB_CA2] = 1'b1;
            end
        end
    end

    // Enable write: direction from the top data bit, mask from the rest
    always_comb begin
        act.ena_wr   = cs && we && (sel == SEL_ENA);
        act.ena_dir  = wdata[DW-1];
        act.ena_mask = wdata[NSRC-1:0];
    end
endmodule

// File: rtl/ifc_flag_bank.sv
// Module: ifc_flag_bank
// Sticky interrupt flags. Set pulses win over clears on the same edge.
// Assumes: synchronous active-low reset.
module ifc_flag_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flag_q
);
    // One independent set/clear cell per source
    for (genvar i = 0; i < N; i++) begin : g_cell
        // Per-flag update: reset, then set priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_pulse[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ifc_enable_bank.sv
// Module: ifc_enable_bank
// Interrupt enable mask with directional write: ones in the mask are set
// or cleared according to dir; zeros leave bits alone.
// Assumes: synchronous active-low reset.
module ifc_enable_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         dir,
    input  logic [N-1:0] mask,
    output logic [N-1:0] en_q
);
    // Apply a directional write to the addressed enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr) begin
            if (dir) begin
                en_q <= en_q | mask;
            end else begin
                en_q <= en_q & ~mask;
            end
        end
    end
endmodule

// File: rtl/ifc_read_view.sv
// Module: ifc_read_view
// Read data multiplexer and interrupt request. The flag view carries the
// pending summary in its top bit; the enable view reads its top bit as one.
// Assumes: unsupported selects return zero.
module ifc_read_view
    import ifc_pkg::*;
(
    input  logic [SW-1:0]   sel,
    input  logic [NSRC-1:0] flag_q,
    input  logic [NSRC-1:0] en_q,
    output logic [DW-1:0]   rdata,
    output logic            irq
);
    logic pending;

    // Summary of enabled and pending sources
    always_comb begin
        pending = |(flag_q & en_q);
        irq     = pending;
    end

    // Select the register view for the bus
    always_comb begin
        unique case (sel)
            SEL_FLAG: rdata = {pending, flag_q};
            SEL_ENA:  rdata = {1'b1, en_q};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ifc_irq_ctrl.sv
// Module: ifc_irq_ctrl (top)
// Interrupt flag/enable controller of a parallel-port and timer peripheral.
// Sources pulse src_set; the CPU clears flags by flag-register writes or by
// port data accesses; irq is the level OR of enabled pending flags.
// Assumes: the control register is held elsewhere and fed in via ctl_mode.
module ifc_irq_ctrl
    import ifc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            we,
    input  logic [SW-1:0]   sel,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   ctl_mode,
    input  logic [NSRC-1:0] src_set,
    output logic [DW-1:0]   rdata,
    output logic            irq
);
    ifc_action_t     act;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;

    ifc_access_decode u_dec (
        .cs       (cs),
        .we       (we),
        .sel      (sel),
        .wdata    (wdata),
        .ctl_mode (ctl_mode),
        .act      (act)
    );

    ifc_flag_bank #(.N(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (src_set),
        .clr_mask  (act.flag_clr),
        .flag_q    (flag_q)
    );

    ifc_enable_bank #(.N(NSRC)) u_ena (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (act.ena_wr),
        .dir   (act.ena_dir),
        .mask  (act.ena_mask),
        .en_q  (en_q)
    );

    ifc_read_view u_view (
        .sel    (sel),
        .flag_q (flag_q),
        .en_q   (en_q),
        .rdata  (rdata),
        .irq    (irq)
    );
endmodule

// File: rtl/ifc_irq_ctrl_chk.sv
// Module: ifc_irq_ctrl_chk
// Property checker for ifc_irq_ctrl, attached through bind below.
// Assumes: observes the top ports and the two register banks.
module ifc_irq_ctrl_chk
    import ifc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cs,
    input logic            we,
    input logic [SW-1:0]   sel,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   ctl_mode,
    input logic [NSRC-1:0] src_set,
    input logic [DW-1:0]   rdata,
    input logic            irq,
    input logic [NSRC-1:0] flag_q,
    input logic [NSRC-1:0] en_q
);
    AST_ENA_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && sel == SEL_ENA && wdata[7]) |=>
        ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0]))); // R2

    AST_ENA_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && sel == SEL_ENA && !wdata[7]) |=>
        ((en_q & $past(wdata[NSRC-1:0])) == '0)); // R3

    AST_ENA_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_ENA) |-> rdata[7]); // R4

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=>
        ((flag_q & $past(src_set)) == $past(src_set))); // R11

    AST_SUMMARY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_FLAG) |-> (rdata[7] == irq)); // R7

    AST_PORTB_CB1_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && sel == SEL_PORTB && !src_set[FB_CB1]) |=> !flag_q[FB_CB1]); // R9

    AST_PORTA_CA1_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (sel == SEL_PORTA || sel == SEL_PORTAQ) && !src_set[FB_CA1])
        |=> !flag_q[FB_CA1]); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && src_set == '0) |=> ($stable(flag_q) && $stable(en_q))); // R5
endmodule

bind ifc_irq_ctrl ifc_irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .we       (we),
    .sel      (sel),
    .wdata    (wdata),
    .ctl_mode (ctl_mode),
    .src_set  (src_set),
    .rdata    (rdata),
    .irq      (irq),
    .flag_q   (flag_q),
    .en_q     (en_q)
);

// File: tb/sim_ifc_irq_ctrl.sv
// Scoreboard bench: the driver applies one cycle of stimulus, predicts the
// pre-edge rdata/irq from a requirement-level model and queues it; the
// monitor samples shortly after the driving edge and compares.
module sim_ifc_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic [3:0] sel = 4'h2;
    logic [7:0] wdata = 8'h00;
    logic [7:0] ctl_mode = 8'h00;
    logic [6:0] src_set = 7'h00;
    logic [7:0] rdata;
    logic       irq;

    typedef struct {
        logic [7:0] rd;
        logic       irq;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic [6:0] mflag = '0;
    logic [6:0] men = '0;
    bit    done = 0;

    always #4 clk = ~clk; // 125 MHz

    ifc_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .sel(sel),
        .wdata(wdata), .ctl_mode(ctl_mode), .src_set(src_set),
        .rdata(rdata), .irq(irq)
    );

    // Driver: one cycle of stimulus, prediction, then model update
    task automatic step(input logic c, input logic w, input logic [3:0] s,
                        input logic [7:0] d, input logic [7:0] mode,
                        input logic [6:0] st, input string tag);
        item_t it;
        logic [6:0] clr;
        @(negedge clk);
        cs = c; we = w; sel = s; wdata = d; ctl_mode = mode; src_set = st;
        it.irq = |(mflag & men);
        if (s == 4'hD)      it.rd = {|(mflag & men), mflag};
        else if (s == 4'hE) it.rd = {1'b1, men};
        else                it.rd = 8'h00;
        it.tag = tag;
        q.push_back(it);
        clr = '0;
        if (c && w && s == 4'hD) clr = d[6:0];
        if (c && s == 4'h0) begin
            clr[4] = 1'b1;
            if ((mode & 8'hA0) != 8'h20) clr[3] = 1'b1;
        end
        if (c && (s == 4'h1 || s == 4'hF)) begin
            clr[1] = 1'b1;
            if ((mode & 8'h0A) != 8'h02) clr[0] = 1'b1;
        end
        mflag = (mflag & ~clr) | st;
        if (c && w && s == 4'hE) men = d[7] ? (men | d[6:0]) : (men & ~d[6:0]);
    endtask

    task automatic rd(input logic [3:0] s, input string tag);
        step(1'b1, 1'b0, s, 8'h00, ctl_mode, 7'h00, tag);
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d, input string tag);
        step(1'b1, 1'b1, s, d, ctl_mode, 7'h00, tag);
    endtask

    task automatic pulse(input logic [6:0] st, input string tag);
        step(1'b0, 1'b0, 4'h2, 8'h00, ctl_mode, st, tag);
    endtask

    // Monitor: compare each queued prediction just after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() != 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (rdata !== it.rd || irq !== it.irq) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                             it.tag, rdata, irq, it.rd, it.irq);
                end
            end
        end
    end

    // Watchdog: counts as a failed check and still reports
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: expired expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(4'hD, "R1");
        rd(4'hE, "R1");
        rd(4'h5, "R12");
        // R2 / R3 / R4: directional enable writes
        wr(4'hE, 8'hC1, "R2");
        rd(4'hE, "R2");
        wr(4'hE, 8'h01, "R3");
        rd(4'hE, "R3");
        wr(4'hE, 8'h00, "R3");
        rd(4'hE, "R4");
        // R5 / R7 / R8: enabled and disabled sources
        pulse(7'h40, "R5");
        rd(4'hD, "R7");
        pulse(7'h04, "R5");
        rd(4'hD, "R8");
        // R6: explicit flag clears; bit 7 stores nothing
        wr(4'hD, 8'h40, "R6");
        rd(4'hD, "R6");
        wr(4'hD, 8'h80, "R6");
        rd(4'hD, "R6");
        rd(4'h3, "R12");
        // R9: port B side effects
        ctl_mode = 8'h00;
        pulse(7'h18, "R9");
        rd(4'h0, "R9");
        rd(4'hD, "R9");
        ctl_mode = 8'h20;
        pulse(7'h18, "R9");
        wr(4'h0, 8'h55, "R9");
        rd(4'hD, "R9");
        ctl_mode = 8'hA0;
        pulse(7'h18, "R9");
        rd(4'h0, "R9");
        rd(4'hD, "R9");
        // R10: port A side effects, both selects
        ctl_mode = 8'h00;
        pulse(7'h03, "R10");
        rd(4'h1, "R10");
        rd(4'hD, "R10");
        ctl_mode = 8'h02;
        pulse(7'h03, "R10");
        wr(4'hF, 8'h00, "R10");
        rd(4'hD, "R10");
        ctl_mode = 8'h0A;
        pulse(7'h03, "R10");
        rd(4'hF, "R10");
        rd(4'hD, "R10");
        // R11: set beats a same-edge clear
        ctl_mode = 8'h00;
        pulse(7'h02, "R11");
        step(1'b1, 1'b1, 4'hD, 8'h02, 8'h00, 7'h02, "R11");
        rd(4'hD, "R11");
        step(1'b1, 1'b0, 4'h0, 8'h00, 8'h00, 7'h10, "R11");
        rd(4'hD, "R11");
        // R8: enable everything, then drain flags
        wr(4'hE, 8'hFF, "R8");
        rd(4'hD, "R8");
        wr(4'hD, 8'h7F, "R8");
        rd(4'hD, "R8");
        // R1: reset in mid-run returns to the idle state
        pulse(7'h7F, "R5");
        @(negedge clk);
        rst_n = 1'b0; cs = 1'b0; src_set = '0;
        @(negedge clk);
        rst_n = 1'b1;
        mflag = '0; men = '0;
        rd(4'hD, "R1");
        rd(4'hE, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule